// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block implements one bank of general-purpose I/O pins. Every pin has its own control word that sets output drive, output enable and pull configuration, reports the sampled pad level, and configures interrupt detection. A bank-level status word gathers every pin's pending interrupt, and one registered interrupt line goes to the host.

Pad inputs first pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier. Three control bits (high, low, edge-select) pick the detection mode: rising edge, falling edge, both edges, high level or low level. A pin's status bit sets whenever its condition is detected, whatever its enable says. The enable only decides whether that status counts toward the bank status word and the interrupt line.

Software acknowledges an interrupt by reading a pin's control word and writing the same value back. The status bit clears on a written 1 and keeps its value on a written 0. Access is through a simple request/write-enable bus with byte addresses. Read data appears one cycle after the request. NPINS may range from 1 to 32.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is asserted and right after it, every pin is an input (pad_oe_o all 0), every control field is 0, all status bits are clear and irq_o is 0.
- R2: Pin i's control word sits at byte address 4*i and the bank status word at byte address 4*NPINS. A read returns its data on rdata_o in the cycle after the request. Reads of any other address, or of an address whose two low bits are not 00, return 0. Writes to such addresses change nothing.
- R3: Control word layout: bit0 data-out, bit1 data-in (read-only), bit2 output-enable, bit3 interrupt-enable, bit4 interrupt-status, bit5 detect-high, bit6 detect-low, bit7 edge-select (1 = edge, 0 = level), bit8 pull-enable, bit9 pull-up (1 = up, 0 = down). Bits 31:10 read 0.
- R4: pad_oe_o[i], pad_o[i], pull_en_o[i] and pull_up_o[i] follow pin i's output-enable, data-out, pull-enable and pull-up fields.
- R5: Data-in reports pad_i[i] after a two-flop synchronizer, so a read issued in the same cycle as a pad change still returns the old value.
- R6: With edge-select=1, high=1/low=0 sets status on a rising edge, high=0/low=1 on a falling edge, and high=1/low=1 on either edge. An edge of the other direction leaves status unchanged.
- R7: With edge-select=0, high=1/low=0 sets status in every cycle the synchronized pad is 1, and high=0/low=1 in every cycle it is 0. A clear therefore has no lasting effect while the level holds, and status stays set after the level goes away until it is cleared.
- R8: A control-word write with bit4=1 clears that pin's status, and one with bit4=0 leaves it unchanged, so writing back a value just read acknowledges the interrupt. A detection in the same cycle wins over the clear.
- R9: Bit i of the bank status word is pin i's status AND its interrupt-enable. Status sets even while the enable is 0. Writes to the status word are ignored.
- R10: irq_o is the OR over all pins of (status AND interrupt-enable), registered once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pad_i | input | NPINS | Pad input levels (asynchronous) |
| pad_o | output | NPINS | Pad output data |
| pad_oe_o | output | NPINS | Pad output enable |
| pull_en_o | output | NPINS | Pull resistor enable |
| pull_up_o | output | NPINS | Pull direction, 1 = up |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
A wrong mode decode or a stale previous-sample register shows up as a status bit that sets or fails to set about three cycles after a pad change. It is visible in bit4 of the control word and, when enabled, on irq_o one cycle later. A broken clear path shows as status staying at 1 after a write-back acknowledge in edge mode, or dropping on a write of 0. Wrong address decoding corrupts a neighbouring pin's control word, which the next read of that word exposes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // control word bit positions
  localparam int CB_DOUT = 0;
  localparam int CB_DIN  = 1;
  localparam int CB_OE   = 2;
  localparam int CB_IE   = 3;
  localparam int CB_ST   = 4;
  localparam int CB_HI   = 5;
  localparam int CB_LO   = 6;
  localparam int CB_EDGE = 7;
  localparam int CB_PEN  = 8;
  localparam int CB_PUP  = 9;
  localparam int CTRL_USED = 10;

  typedef struct packed {
    logic pup;
    logic pen;
    logic edge_sel;
    logic lo;
    logic hi;
    logic ie;
    logic oe;
    logic dout;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_o    = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  pin_cfg_t cfg_wr_i,
  input  logic     clr_i,
  input  logic     sync_i,
  input  logic     prev_i,
  output pin_cfg_t cfg_o,
  output logic     st_o,
  output logic     hit_o
);
  pin_cfg_t cfg_q;
  logic     st_q;
  logic     rise, fall, edge_hit, lvl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_wr_i;
  end

  assign rise     = sync_i & ~prev_i;
  assign fall     = ~sync_i & prev_i;
  assign edge_hit = (cfg_q.hi & rise) | (cfg_q.lo & fall);
  assign lvl_hit  = (cfg_q.hi & sync_i) | (cfg_q.lo & ~sync_i);
  assign hit_o    = cfg_q.edge_sel ? edge_hit : lvl_hit;

  // detection wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= (st_q & ~(wr_i & clr_i)) | hit_o;
  end

  assign cfg_o = cfg_q;
  assign st_o  = st_q;
endmodule

// File: rtl/gpio_bank_regif.sv
module gpio_bank_regif
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  pin_cfg_t [NPINS-1:0]  cfg_i,
  input  logic [NPINS-1:0]      st_i,
  input  logic [NPINS-1:0]      sync_i,
  output logic [NPINS-1:0]      wr_sel_o,
  output logic [31:0]           rdata_o
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0] word;
  logic          aligned;
  logic [31:0]   rd_d, rdata_q;
  logic [NPINS-1:0] ie_v;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NPINS; g++) begin : g_sel
    assign wr_sel_o[g] = req_i & we_i & aligned & (int'(word) == g);
    assign ie_v[g]     = cfg_i[g].ie;
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      for (int k = 0; k < NPINS; k++) begin
        if (int'(word) == k)
          rd_d = {22'b0, cfg_i[k].pup, cfg_i[k].pen, cfg_i[k].edge_sel, cfg_i[k].lo,
                  cfg_i[k].hi, st_i[k], cfg_i[k].ie, cfg_i[k].oe, sync_i[k], cfg_i[k].dout};
      end
      if (int'(word) == NPINS) rd_d[NPINS-1:0] = st_i & ie_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = $clog2(NPINS + 1) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pull_en_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic              irq_o
);
  pin_cfg_t [NPINS-1:0] cfg;
  pin_cfg_t             cfg_wr;
  logic [NPINS-1:0]     sync_v, prev_v, st_v, hit_v, wr_sel;
  logic [NPINS-1:0]     ie_v, hi_v, lo_v, edge_v;
  logic                 irq_q;
  logic                 unused_wdata;

  assign cfg_wr = '{pup:      wdata_i[CB_PUP],
                    pen:      wdata_i[CB_PEN],
                    edge_sel: wdata_i[CB_EDGE],
                    lo:       wdata_i[CB_LO],
                    hi:       wdata_i[CB_HI],
                    ie:       wdata_i[CB_IE],
                    oe:       wdata_i[CB_OE],
                    dout:     wdata_i[CB_DOUT]};
  assign unused_wdata = ^{wdata_i[31:CTRL_USED], wdata_i[CB_DIN]};

  gpio_bank_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (sync_v),
    .prev_o (prev_v)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_bank_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_sel[g]),
      .cfg_wr_i (cfg_wr),
      .clr_i    (wdata_i[CB_ST]),
      .sync_i   (sync_v[g]),
      .prev_i   (prev_v[g]),
      .cfg_o    (cfg[g]),
      .st_o     (st_v[g]),
      .hit_o    (hit_v[g])
    );
    assign pad_o[g]     = cfg[g].dout;
    assign pad_oe_o[g]  = cfg[g].oe;
    assign pull_en_o[g] = cfg[g].pen;
    assign pull_up_o[g] = cfg[g].pup;
    assign ie_v[g]      = cfg[g].ie;
    assign hi_v[g]      = cfg[g].hi;
    assign lo_v[g]      = cfg[g].lo;
    assign edge_v[g]    = cfg[g].edge_sel;
  end

  gpio_bank_regif #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .cfg_i    (cfg),
    .st_i     (st_v),
    .sync_i   (sync_v),
    .wr_sel_o (wr_sel),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(st_v & ie_v);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              clr_i,
  input logic [31:0]       rdata_o,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  st_q,
  input logic [NPINS-1:0]  ie_q,
  input logic [NPINS-1:0]  hi_q,
  input logic [NPINS-1:0]  lo_q,
  input logic [NPINS-1:0]  edge_q,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  wr_sel
);
  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(4 * NPINS);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_oe_o == '0 && !irq_o));

  a_r10_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(st_q & ie_q)));

  a_r2_status_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ST_ADDR) |=> rdata_o == $past(32'(st_q & ie_q)));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    a_r8_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(st_q[g]) |-> $past(wr_sel[g] && clr_i));

    a_r7_level_high_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_q[g] && hi_q[g] && sync_q[g]) |=> st_q[g]);

    a_r7_level_low_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_q[g] && lo_q[g] && !sync_q[g]) |=> st_q[g]);
  end
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .clr_i    (wdata_i[4]),
  .rdata_o  (rdata_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .st_q     (st_v),
  .ie_q     (ie_v),
  .hi_q     (hi_v),
  .lo_q     (lo_v),
  .edge_q   (edge_v),
  .sync_q   (sync_v),
  .wr_sel   (wr_sel)
);

// File: tb/gpio_bank_irq_tb.sv
`timescale 1ns/1ps
module gpio_bank_irq_tb;
  localparam int NPINS  = 32;
  localparam int ADDR_W = $clog2(NPINS + 1) + 2;
  localparam logic [31:0] CFG_MASK = 32'h3ED;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NPINS-1:0]  pad_i = '0;
  logic [NPINS-1:0]  pad_o, pad_oe_o, pull_en_o, pull_up_o;
  logic              irq_o;

  gpio_bank_irq #(.NPINS(NPINS)) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_i, .pad_o, .pad_oe_o, .pull_en_o, .pull_up_o, .irq_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [31:0]      m_cfg [NPINS];
  logic [NPINS-1:0] m_st = '0, pad_v = '0;

  function automatic logic lvl(logic [31:0] c, logic p);
    return !c[7] && ((c[5] && p) || (c[6] && !p));
  endfunction
  function automatic logic edg(logic [31:0] c, logic o, logic n);
    return c[7] && ((c[5] && !o && n) || (c[6] && o && !n));
  endfunction
  function automatic logic [31:0] exp_ctrl(int i);
    return (m_cfg[i] & CFG_MASK) | (32'(pad_v[i]) << 1) | (32'(m_st[i]) << 4);
  endfunction
  function automatic logic [NPINS-1:0] field(int b);
    logic [NPINS-1:0] v;
    for (int k = 0; k < NPINS; k++) v[k] = m_cfg[k][b];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_wr(int i, logic [31:0] d);
    logic [31:0] nc;
    bus_wr(ADDR_W'(4 * i), d);
    nc = d & CFG_MASK;
    m_st[i] = (m_st[i] & !d[4]) | lvl(m_cfg[i], pad_v[i]) | lvl(nc, pad_v[i]);
    m_cfg[i] = nc;
    idle(6);
  endtask

  task automatic do_pad(logic [NPINS-1:0] v);
    @(negedge clk_i);
    pad_i = v;
    idle(6);
    for (int k = 0; k < NPINS; k++)
      m_st[k] = m_st[k] | edg(m_cfg[k], pad_v[k], v[k]) | lvl(m_cfg[k], v[k]);
    pad_v = v;
  endtask

  task automatic rd_ctrl(int i, output logic [31:0] d);
    bus_rd(ADDR_W'(4 * i), d);
  endtask

  task automatic check_all(int i);
    logic [31:0] d;
    logic [NPINS-1:0] ie;
    ie = field(3);
    rd_ctrl(i, d);
    chk("R3 ctrl", d, exp_ctrl(i));
    bus_rd(ADDR_W'(4 * NPINS), d);
    chk("R9 status", d, 32'(m_st & ie));
    chk("R10 irq", 32'(irq_o), 32'(|(m_st & ie)));
    chk("R4 oe", 32'(pad_oe_o), 32'(field(2)));
    chk("R4 dout", 32'(pad_o), 32'(field(0)));
    chk("R4 pull", 32'({pull_en_o, pull_up_o}), 32'({field(8), field(9)}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NPINS; k++) m_cfg[k] = '0;

    // R1 reset
    idle(3);
    chk("R1 oe in reset", 32'(pad_oe_o), 32'h0);
    chk("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    idle(2);
    rd_ctrl(0, d);           chk("R1 ctrl0", d, 32'h0);
    rd_ctrl(NPINS - 1, d);   chk("R1 ctrl last", d, 32'h0);
    bus_rd(ADDR_W'(4 * NPINS), d); chk("R1 status", d, 32'h0);

    // R4 drive/pull
    do_wr(2, 32'hFFFF_FC05 | 32'h300);
    chk("R4 oe2", 32'(pad_oe_o[2]), 32'h1);
    chk("R4 dout2", 32'(pad_o[2]), 32'h1);
    chk("R4 pen2", 32'(pull_en_o[2]), 32'h1);
    chk("R4 pup2", 32'(pull_up_o[2]), 32'h1);
    rd_ctrl(2, d); chk("R3 upper bits zero", d, 32'h305);

    // R2 decode
    bus_rd(ADDR_W'(4 * NPINS + 4), d); chk("R2 unmapped read", d, 32'h0);
    bus_rd(ADDR_W'(9), d);             chk("R2 misaligned read", d, 32'h0);
    bus_wr(ADDR_W'(9), 32'h0);
    idle(2);
    rd_ctrl(2, d); chk("R2 misaligned write ignored", d, 32'h305);

    // R5 synchronizer latency on data-in
    @(negedge clk_i);
    pad_i[3] = 1'b1; req_i = 1'b1; we_i = 1'b0; addr_i = ADDR_W'(12);
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R5 din not yet visible", rdata_o, 32'h0);
    idle(4);
    pad_v[3] = 1'b1;
    rd_ctrl(3, d); chk("R5 din visible", d, 32'h2);

    // R6 rising edge on pin 5
    do_wr(5, 32'hA8);
    rd_ctrl(5, d); chk("R6 rising armed", d, 32'hA8);
    do_pad(pad_v | (NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 rising sets", d, 32'hBA);
    chk("R10 irq on rise", 32'(irq_o), 32'h1);
    bus_rd(ADDR_W'(4 * NPINS), d); chk("R9 status bit5", d, 32'h20);
    rd_ctrl(5, d); do_wr(5, d);
    rd_ctrl(5, d); chk("R8 write-back ack", d, 32'hAA);
    chk("R10 irq drops", 32'(irq_o), 32'h0);
    do_pad(pad_v & ~(NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 fall ignored in rising mode", d, 32'hA8);

    // R6 falling
    do_wr(5, 32'hC8);
    do_pad(pad_v | (NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 rise ignored in falling mode", d, 32'hCA);
    do_pad(pad_v & ~(NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 falling sets", d, 32'hD8);

    // R6 both edges, R8 write 0 keeps
    do_wr(5, 32'hF8);
    rd_ctrl(5, d); chk("R8 clear", d, 32'hE8);
    do_pad(pad_v | (NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 both: rise", d, 32'hFA);
    do_wr(5, 32'hE8);
    rd_ctrl(5, d); chk("R8 write 0 keeps status", d, 32'hFA);
    do_wr(5, 32'hF8);
    do_pad(pad_v & ~(NPINS'(1) << 5));
    rd_ctrl(5, d); chk("R6 both: fall", d, 32'hF8);
    do_wr(5, 32'h10);
    rd_ctrl(5, d); chk("R8 cleanup", d, 32'h0);

    // R7 level modes on pin 7
    do_wr(7, 32'h28);
    do_pad(pad_v | (NPINS'(1) << 7));
    rd_ctrl(7, d); chk("R7 high level sets", d, 32'h3A);
    do_wr(7, 32'h38);
    rd_ctrl(7, d); chk("R7 clear ineffective while high", d, 32'h3A);
    do_pad(pad_v & ~(NPINS'(1) << 7));
    rd_ctrl(7, d); chk("R7 status latched after level", d, 32'h38);
    do_wr(7, 32'h38);
    rd_ctrl(7, d); chk("R7 clear after level gone", d, 32'h28);
    do_wr(7, 32'h48);
    rd_ctrl(7, d); chk("R7 low level sets", d, 32'h58);
    do_pad(pad_v | (NPINS'(1) << 7));
    do_wr(7, 32'h58);
    rd_ctrl(7, d); chk("R7 low cleared once high", d, 32'h4A);
    do_wr(7, 32'h10);

    // R9 enable gating, status word write ignored
    do_wr(9, 32'hA0);
    do_pad(pad_v | (NPINS'(1) << 9));
    rd_ctrl(9, d); chk("R9 status sets without enable", d, 32'hB2);
    bus_rd(ADDR_W'(4 * NPINS), d); chk("R9 masked by enable", d, 32'h0);
    chk("R10 no irq when disabled", 32'(irq_o), 32'h0);
    bus_wr(ADDR_W'(4 * NPINS), 32'hFFFF_FFFF);
    idle(3);
    rd_ctrl(9, d); chk("R9 status write ignored", d, 32'hB2);
    do_wr(9, 32'hA8);
    bus_rd(ADDR_W'(4 * NPINS), d); chk("R9 enabled pending", d, 32'h200);
    chk("R10 irq when enabled", 32'(irq_o), 32'h1);
    do_wr(9, 32'h10);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int pin;
      int op;
      pin = int'($urandom % NPINS);
      op  = int'($urandom % 4);
      case (op)
        0: do_wr(pin, $urandom & 32'h3FF);
        1: do_pad(pad_v ^ NPINS'($urandom & $urandom & $urandom));
        2: begin rd_ctrl(pin, d); do_wr(pin, d); end
        default: do_wr(pin, ($urandom & 32'h3EF) | 32'h80);
      endcase
      check_all(pin);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule